// File: doc/BRIEF.md
# Legacy Interrupt Replacement Router

The router sits between a bank of event-timer channels, two older timer sources and the system interrupt lines. The older sources are an interval-timer output and a real-time-clock interrupt. Each channel presents one interrupt signal, which is either a held level or a one-cycle pulse, together with a route field that selects a destination line. The router combines everything into a registered vector of interrupt lines. Line 0 is the interval-timer line and line 8 is the clock line.

A single mode input switches the router into legacy-replacement mode. In that mode channel 0 takes over line 0 and channel 1 takes over line 8, and the two older sources are masked. The router also drives an enable output back to the interval timer so that the timer can stop while it is replaced.

Mode changes follow a fixed sequence. When the router enters the mode, lines 0 and 8 are cleared and the enable output falls. When it leaves the mode, line 0 is cleared, the enable output rises, and line 8 takes the last clock level the router recorded. The router records that level continuously, including while the clock source is masked.

Top module: `lrr_router`

## Requirements
- R1: Normal mode. A channel whose signal is high drives the line whose index equals its route field. The line becomes visible one cycle later.
- R2: When several sources map to the same line, the line is the OR of those sources.
- R3: A line that no active source maps to is low. A route field value at or above the number of lines reaches no line.
- R4: Normal mode. The interval-timer input is ORed onto line 0 and the clock input is ORed onto line 8.
- R5: Legacy mode. Channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. All other channels keep using their route fields.
- R6: Legacy mode. The interval-timer and clock inputs have no effect on any line.
- R7: In the cycle that follows the first edge at which the mode input reads high after being low, lines 0 and 8 are low and the interval-timer enable is low.
- R8: In the cycle that follows the first edge at which the mode input reads low after being high, line 0 is low, the interval-timer enable is high, and line 8 equals the clock input level sampled at the edge one cycle before.
- R9: The clock input level is recorded at every edge, including edges where legacy mode masks it. The level that R8 restores is the latest such recording.
- R10: While reset is asserted, all lines are low, the interval-timer enable is high, and the recorded clock level is 0.
- R11: Every output is registered. A one-cycle pulse on a channel gives a one-cycle pulse on its line, delayed by exactly one cycle.
- R12: The interval-timer enable is the inverse of the mode input from the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| legacyMode | input | 1 | 1 selects legacy-replacement routing |
| chanIrq | input | NUM_CH | Interrupt signal from each channel, level or one-cycle pulse |
| chanRoute | input | NUM_CH*ROUTE_W | Route field of each channel; channel c occupies bits [c*ROUTE_W +: ROUTE_W] |
| pitIn | input | 1 | Interval-timer interrupt source |
| rtcIn | input | 1 | Real-time-clock interrupt source |
| irqLines | output | NUM_LINES | Registered system interrupt lines |
| pitEnable | output | 1 | Enable returned to the interval timer |

## Verification
A stale mode register shows up on the first edge after a mode change. It either fails to clear lines 0 and 8 or fails to move the enable output, so the error is visible one cycle after the change. A recorded clock level that is stale or never updated while the source is masked stays hidden for the whole legacy period. It appears only on line 8 in the single cycle after the mode is left, so the bench changes the clock input inside legacy mode just before leaving. A wrong route decode shows at once on the line the bench expected and on the line that was driven by mistake, one cycle after the channel input.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
  localparam int PIT_LINE = 0;
  localparam int RTC_LINE = 8;

  typedef struct packed {
    logic enterLegacy;
    logic leaveLegacy;
    logic legacyOn;
    logic rtcHeld;
  } modeStrobe_t;
endpackage

// File: rtl/lrr_ctrl.sv
module lrr_ctrl
  import lrr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        legacyMode,
  input  logic        rtcIn,
  output modeStrobe_t strobe,
  output logic        pitEnable
);
  logic legacyQ;
  logic rtcSeenQ;
  logic pitEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      legacyQ  <= 1'b0;
      rtcSeenQ <= 1'b0;
      pitEnQ   <= 1'b1;
    end else begin
      legacyQ  <= legacyMode;
      rtcSeenQ <= rtcIn;
      pitEnQ   <= ~legacyMode;
    end
  end

  always_comb begin
    strobe.enterLegacy = legacyMode & ~legacyQ;
    strobe.leaveLegacy = ~legacyMode & legacyQ;
    strobe.legacyOn    = legacyMode;
    strobe.rtcHeld     = rtcSeenQ;
  end

  assign pitEnable = pitEnQ;
endmodule

// File: rtl/lrr_datapath.sv
module lrr_datapath
  import lrr_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 24,
  parameter int ROUTE_W   = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  modeStrobe_t               strobe,
  input  logic [NUM_CH-1:0]         chanIrq,
  input  logic [NUM_CH*ROUTE_W-1:0] chanRoute,
  input  logic                      pitIn,
  input  logic                      rtcIn,
  output logic [NUM_LINES-1:0]      irqLines
);
  logic [NUM_CH-1:0][ROUTE_W-1:0] dest;
  logic [NUM_CH-1:0]              destOk;
  logic [NUM_LINES-1:0]           chanHit;
  logic [NUM_LINES-1:0]           nextLines;
  logic [NUM_LINES-1:0]           linesQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : gDest
    if (c == 0) begin : gCh0
      assign dest[c] = strobe.legacyOn ? ROUTE_W'(PIT_LINE)
                                       : chanRoute[c*ROUTE_W +: ROUTE_W];
    end else if (c == 1) begin : gCh1
      assign dest[c] = strobe.legacyOn ? ROUTE_W'(RTC_LINE)
                                       : chanRoute[c*ROUTE_W +: ROUTE_W];
    end else begin : gChN
      assign dest[c] = chanRoute[c*ROUTE_W +: ROUTE_W];
    end
    assign destOk[c] = chanIrq[c] && (32'(dest[c]) < NUM_LINES);
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : gLine
    always_comb begin
      chanHit[l] = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        chanHit[l] = chanHit[l] | (destOk[c] && (dest[c] == ROUTE_W'(l)));
      end
    end
  end

  always_comb begin
    nextLines = chanHit;
    if (!strobe.legacyOn) begin
      nextLines[PIT_LINE] = nextLines[PIT_LINE] | pitIn;
      nextLines[RTC_LINE] = nextLines[RTC_LINE] | rtcIn;
    end
    if (strobe.enterLegacy) begin
      nextLines[PIT_LINE] = 1'b0;
      nextLines[RTC_LINE] = 1'b0;
    end
    if (strobe.leaveLegacy) begin
      nextLines[PIT_LINE] = 1'b0;
      nextLines[RTC_LINE] = strobe.rtcHeld;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linesQ <= '0;
    else       linesQ <= nextLines;
  end

  assign irqLines = linesQ;
endmodule

// File: rtl/lrr_router.sv
module lrr_router
  import lrr_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 24,
  parameter int ROUTE_W   = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      legacyMode,
  input  logic [NUM_CH-1:0]         chanIrq,
  input  logic [NUM_CH*ROUTE_W-1:0] chanRoute,
  input  logic                      pitIn,
  input  logic                      rtcIn,
  output logic [NUM_LINES-1:0]      irqLines,
  output logic                      pitEnable
);
  modeStrobe_t strobe;

  lrr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .legacyMode (legacyMode),
    .rtcIn      (rtcIn),
    .strobe     (strobe),
    .pitEnable  (pitEnable)
  );

  lrr_datapath #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .ROUTE_W   (ROUTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .chanIrq   (chanIrq),
    .chanRoute (chanRoute),
    .pitIn     (pitIn),
    .rtcIn     (rtcIn),
    .irqLines  (irqLines)
  );
endmodule

// File: rtl/lrr_router_chk.sv
module lrr_router_chk #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 24,
  parameter int ROUTE_W   = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      legacyMode,
  input logic [NUM_CH-1:0]         chanIrq,
  input logic [NUM_CH*ROUTE_W-1:0] chanRoute,
  input logic                      pitIn,
  input logic                      rtcIn,
  input logic [NUM_LINES-1:0]      irqLines,
  input logic                      pitEnable
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R12: enable output follows the inverted mode one cycle later
  a_r12_pit_enable_tracks: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (pitEnable == !$past(legacyMode)));

  // R7: entry clears lines 0 and 8
  a_r7_enter_clears: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $rose(legacyMode)) |=> (!irqLines[0] && !irqLines[8] && !pitEnable));

  // R8: exit clears line 0 and restores line 8 from the recorded clock level
  a_r8_leave_restores: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $fell(legacyMode)) |=>
      (!irqLines[0] && pitEnable && (irqLines[8] == $past(rtcIn, 2))));

  // R6: steady legacy mode with idle channels leaves every line low
  a_r6_legacy_masks: assert property (@(posedge clk) disable iff (!rstN)
    (armed && legacyMode && $past(legacyMode) && (chanIrq == '0)) |=>
      (irqLines == '0));

  // R11: all lines idle when no source is active in normal mode
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !legacyMode && !$past(legacyMode) && (chanIrq == '0) && !pitIn && !rtcIn)
      |=> (irqLines == '0));
endmodule

bind lrr_router lrr_router_chk #(
  .NUM_CH    (NUM_CH),
  .NUM_LINES (NUM_LINES),
  .ROUTE_W   (ROUTE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .legacyMode (legacyMode),
  .chanIrq    (chanIrq),
  .chanRoute  (chanRoute),
  .pitIn      (pitIn),
  .rtcIn      (rtcIn),
  .irqLines   (irqLines),
  .pitEnable  (pitEnable)
);

// File: tb/lrr_router_tb.sv
module lrr_router_tb;
  localparam int NCH = 4;
  localparam int NL  = 24;
  localparam int RW  = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rstN;
  logic            legacyMode;
  logic [NCH-1:0]  chanIrq;
  logic [NCH*RW-1:0] chanRoute;
  logic            pitIn, rtcIn;
  logic [NL-1:0]   irqLines;
  logic            pitEnable;

  lrr_router #(.NUM_CH(NCH), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .chanIrq(chanIrq),
    .chanRoute(chanRoute), .pitIn(pitIn), .rtcIn(rtcIn),
    .irqLines(irqLines), .pitEnable(pitEnable)
  );

  typedef struct {
    logic [NL-1:0] lines;
    logic          pitEn;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  logic mLegacy = 1'b0;
  logic mRtc = 1'b0;

  function automatic exp_t model(logic lg, logic [NCH-1:0] ch, logic [NCH*RW-1:0] rt,
                                 logic p, logic r, string tag);
    exp_t e;
    e.lines = '0;
    for (int c = 0; c < NCH; c++) begin
      int d = int'(rt[c*RW +: RW]);
      if (lg && c == 0) d = 0;
      if (lg && c == 1) d = 8;
      if (ch[c] && d < NL) e.lines[d] = 1'b1;
    end
    if (!lg) begin
      e.lines[0] = e.lines[0] | p;
      e.lines[8] = e.lines[8] | r;
    end
    if (lg && !mLegacy) begin
      e.lines[0] = 1'b0;
      e.lines[8] = 1'b0;
    end
    if (!lg && mLegacy) begin
      e.lines[0] = 1'b0;
      e.lines[8] = mRtc;
    end
    e.pitEn = !lg;
    e.tag = tag;
    return e;
  endfunction

  function automatic logic [NCH*RW-1:0] routes(int r0, int r1, int r2, int r3);
    return {RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
  endfunction

  task automatic drive(logic lg, logic [NCH-1:0] ch, logic [NCH*RW-1:0] rt,
                       logic p, logic r, string tag);
    @(negedge clk);
    legacyMode = lg; chanIrq = ch; chanRoute = rt; pitIn = p; rtcIn = r;
    q.push_back(model(lg, ch, rt, p, r, tag));
    mLegacy = lg;
    mRtc = r;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (irqLines !== e.lines || pitEnable !== e.pitEn) begin
          bad++;
          $display("FAIL %s lines act=%h exp=%h pitEnable act=%b exp=%b",
                   e.tag, irqLines, e.lines, pitEnable, e.pitEn);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NCH*RW-1:0] rtA;
    rstN = 1'b0; legacyMode = 1'b0; chanIrq = '0; chanRoute = '0; pitIn = 1'b1; rtcIn = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    total++;
    if (irqLines !== '0 || pitEnable !== 1'b1) begin
      bad++;
      $display("FAIL R10 reset act=%h/%b exp=0/1", irqLines, pitEnable);
    end
    @(negedge clk);
    pitIn = 1'b0; rtcIn = 1'b0;
    rstN = 1'b1;

    rtA = routes(3, 5, 12, 20);
    drive(0, 4'b1111, rtA, 0, 0, "R1 all channels routed");
    drive(0, 4'b0101, rtA, 0, 0, "R1 subset routed");
    drive(0, 4'b0001, routes(0, 5, 12, 12), 1, 0, "R2 pit and channel on line 0");
    drive(0, 4'b1100, routes(0, 5, 12, 12), 0, 0, "R2 two channels on line 12");
    drive(0, 4'b1000, routes(3, 5, 12, 30), 0, 0, "R3 out of range route");
    drive(0, 4'b0000, rtA, 0, 0, "R3 unused lines low");
    drive(0, 4'b0000, rtA, 1, 1, "R4 legacy sources pass through");
    drive(0, 4'b0000, rtA, 0, 1, "R4 clock only");
    drive(0, 4'b0010, rtA, 0, 0, "R11 pulse high");
    drive(0, 4'b0000, rtA, 0, 0, "R11 pulse ends");
    drive(1, 4'b0011, rtA, 1, 1, "R7 enter legacy");
    drive(1, 4'b0011, rtA, 1, 0, "R5 ch0 ch1 replaced");
    drive(1, 4'b0100, rtA, 0, 1, "R5 other channel keeps route");
    drive(1, 4'b0000, rtA, 1, 1, "R6 sources masked");
    drive(1, 4'b0000, rtA, 1, 0, "R9 clock low while masked");
    drive(1, 4'b0000, rtA, 0, 1, "R9 clock high while masked");
    drive(0, 4'b0000, rtA, 1, 0, "R8 leave restores high clock");
    drive(0, 4'b0000, rtA, 1, 1, "R12 normal again");
    drive(1, 4'b0001, rtA, 0, 1, "R7 enter again");
    drive(1, 4'b0000, rtA, 0, 0, "R9 clock falls while masked");
    drive(0, 4'b0010, rtA, 1, 1, "R8 leave restores low clock");
    drive(0, 4'b0000, rtA, 0, 0, "R12 enable stays high");
    @(negedge clk);
    legacyMode = 1'b0; chanIrq = '0; pitIn = 1'b0; rtcIn = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule